// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

This block is a port of 32 general-purpose pins that software reaches over a plain register bus. The bus has an address, a write strobe, write data and combinational read data, and every access completes in one cycle. Each pin has an output level bit and a drive-enable bit. The external pad logic takes these two bits, and the pad's sampled level comes back in on `pin_in`.

Incoming levels pass through a two-stage synchroniser. The synchronised level feeds one trigger detector per pin. Each pin selects its detector mode through a 2-bit field, and the fields for the 32 pins are spread over two configuration words. A detected trigger sets that pin's bit in a sticky status register, which software clears by writing ones. A mask register selects which status bits can reach the single port interrupt line.

The register bus is a control path and not a stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `bus_we` is high. A read returns the addressed register in the same cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output-level, drive-enable, both configuration and mask registers read 0. `pin_out`, `pin_oe` and `irq` are low.
- R2: The output-level register sits at offset 0x00 and reads back what was written. `pin_out` follows it from the cycle after the write.
- R3: The drive-enable register sits at offset 0x04, where bit n = 1 makes pin n an output. `pin_oe` follows it from the cycle after the write, and the register reads back.
- R4: Offset 0x08 is read-only. It returns `pin_in` delayed by two register stages, and writes to it change nothing.
- R5: The mode field of pin n occupies bits 2*(n mod 16)+1:2*(n mod 16). It lives at offset 0x0C for pins 0–15 and at offset 0x10 for pins 16–31, and both words read back.
- R6: Mode 00 triggers while the synchronised level is low, and mode 01 triggers while it is high. A level trigger sets the status bit again on every cycle the level persists, including the cycle right after a clear.
- R7: Mode 10 triggers once on a synchronised low-to-high change, and mode 11 triggers once on a high-to-low change. After such a bit has been cleared it stays clear until the next edge.
- R8: The status register sits at offset 0x18. Writing 1 to a bit clears it, writing 0 leaves it as it was, and writing all ones clears every bit that has no new trigger.
- R9: A trigger and a clear that reach the same status bit in the same cycle leave that bit set.
- R10: The mask register sits at offset 0x14. `irq` is high exactly when some bit is set in both status and mask, so a mask bit of 1 enables its pin.
- R11: Offset 0x1C is unmapped: it reads 0 and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | 32 | Levels sampled at the pads |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Per-pin drive enable, 1 = output |
| irq | output | 1 | Port interrupt |

## Verification
The bench places a status clear in the same cycle as a rising-edge trigger on that pin. A design where the clear took priority would lose the event and read the bit back as 0.

A high-level pin is cleared while its level still holds. A design that latched level triggers like edges would leave the bit clear.

Pins whose edge runs against their configured mode, such as a rise on a falling-mode pin, must not set status, which catches swapped mode encodings or a pin fed from the wrong configuration half. Partial clears and masked-off pending bits check that zero bits in a clear write and zero mask bits are really ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_RISE = 2'b10,
    TRG_FALL = 2'b11
  } trig_mode_e;

  localparam logic [REG_AW-1:0] OFS_OUT  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_DIR  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_PAD  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CFGL = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CFGH = 5'h10;
  localparam logic [REG_AW-1:0] OFS_MASK = 5'h14;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   lvl,
  input  logic [2*NPIN-1:0] cfg,
  output logic [NPIN-1:0]   trig
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    trig_mode_e mode;
    assign mode = trig_mode_e'(cfg[2*g +: 2]);
    always_comb begin
      case (mode)
        TRG_LOW:  trig[g] = !lvl[g];
        TRG_HIGH: trig[g] = lvl[g];
        TRG_RISE: trig[g] = lvl[g] && !prev_q[g];
        default:  trig[g] = !lvl[g] && prev_q[g];
      endcase
    end
  end
endmodule

// File: rtl/gpio_stat.sv
module gpio_stat #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] trig,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | trig;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  localparam int CW = 2 * NPIN;

  logic [NPIN-1:0] out_q, dir_q, mask_q;
  logic [CW-1:0]   cfg_q;
  logic [NPIN-1:0] pad_w, trig_w, stat_q, clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      cfg_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_OUT:  out_q  <= bus_wdata;
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_MASK: mask_q <= bus_wdata;
        OFS_CFGL: cfg_q[NPIN-1:0]  <= bus_wdata;
        OFS_CFGH: cfg_q[CW-1:NPIN] <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_w = (bus_we && bus_addr == OFS_STAT) ? bus_wdata : '0;

  gpio_sync #(.W(NPIN)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_w)
  );

  gpio_trig #(.NPIN(NPIN)) trig_i (
    .clk(clk), .rst_n(rst_n), .lvl(pad_w), .cfg(cfg_q), .trig(trig_w)
  );

  gpio_stat #(.NPIN(NPIN)) stat_i (
    .clk(clk), .rst_n(rst_n), .trig(trig_w), .clr(clr_w), .stat_q(stat_q)
  );

  always_comb begin
    case (bus_addr)
      OFS_OUT:  bus_rdata = out_q;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_PAD:  bus_rdata = pad_w;
      OFS_CFGL: bus_rdata = cfg_q[NPIN-1:0];
      OFS_CFGH: bus_rdata = cfg_q[CW-1:NPIN];
      OFS_MASK: bus_rdata = mask_q;
      OFS_STAT: bus_rdata = stat_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic [NPIN-1:0]   trig,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   mask
);
  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_OUT) |=> (pin_out == $past(bus_wdata)));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_STAT) |=>
      ((stat & $past(bus_wdata) & ~$past(trig)) == '0));

  // R9
  trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((stat & $past(trig)) == $past(trig)));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(trig)) == '0));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .trig(trig_w), .stat(stat_q), .mask(mask_q)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_out, m_dir, m_mask, m_cfgl, m_cfgh, m_stat;
  logic [31:0] m_s1, m_s2, m_prev;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_out;
      5'h04: return m_dir;
      5'h08: return m_s2;
      5'h0C: return m_cfgl;
      5'h10: return m_cfgh;
      5'h14: return m_mask;
      5'h18: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_mask = 0; m_cfgl = 0; m_cfgh = 0;
      m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      logic [31:0] t;
      logic [31:0] clr;
      t = 0;
      for (int i = 0; i < 32; i++) begin
        logic [31:0] word;
        int mode;
        word = (i < 16) ? m_cfgl : m_cfgh;
        mode = int'((word >> (2 * (i % 16))) & 32'h3);
        case (mode)
          0: t[i] = !m_s2[i];
          1: t[i] = m_s2[i];
          2: t[i] = m_s2[i] && !m_prev[i];
          default: t[i] = !m_s2[i] && m_prev[i];
        endcase
      end
      clr = (bus_we && bus_addr == 5'h18) ? bus_wdata : 32'h0;
      m_stat = (m_stat & ~clr) | t;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_we) begin
        case (bus_addr)
          5'h00: m_out = bus_wdata;
          5'h04: m_dir = bus_wdata;
          5'h0C: m_cfgl = bus_wdata;
          5'h10: m_cfgh = bus_wdata;
          5'h14: m_mask = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 pin_out model", pin_out, m_out);
      check("R3 pin_oe model", pin_oe, m_dir);
      check("R10 irq model", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
      check("R11 rdata model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      bus_we = 1'b0;
    end
  endtask

  task automatic setpin(input logic [31:0] v);
    @(negedge clk); #1;
    bus_we = 1'b0; pin_in = v;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_out reset", pin_out, 32'h0);
    check("R1 pin_oe reset", pin_oe, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
    rd_chk(5'h0C, 32'h0, "R1 cfg low reset");
    rd_chk(5'h10, 32'h0, "R1 cfg high reset");
    rd_chk(5'h14, 32'h0, "R1 mask reset");

    wr(5'h00, 32'hA5A5_0F0F);
    rd_chk(5'h00, 32'hA5A5_0F0F, "R2 out readback");
    check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    rd_chk(5'h04, 32'hFFFF_0000, "R3 dir readback");
    check("R3 pin_oe", pin_oe, 32'hFFFF_0000);

    wr(5'h0C, 32'hAAAA_AAAA);
    wr(5'h10, 32'hFFFF_FFFF);
    rd_chk(5'h0C, 32'hAAAA_AAAA, "R5 cfg low readback");
    rd_chk(5'h10, 32'hFFFF_FFFF, "R5 cfg high readback");
    wr(5'h18, 32'hFFFF_FFFF);
    idle(2);
    rd_chk(5'h18, 32'h0, "R8 clear all");

    setpin(32'h0001_0003);
    idle(3);
    rd_chk(5'h08, 32'h0001_0003, "R4 pad status");
    wr(5'h08, 32'h1234_5678);
    rd_chk(5'h08, 32'h0001_0003, "R4 pad write ignored");
    rd_chk(5'h18, 32'h0000_0003, "R7 rise set, fall-mode pin16 quiet");
    check("R10 masked irq low", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h0000_0001);
    idle(1);
    check("R10 unmasked irq high", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h0000_0002);
    rd_chk(5'h18, 32'h0000_0001, "R8 partial clear");

    setpin(32'h0000_0003);
    idle(3);
    rd_chk(5'h18, 32'h0001_0001, "R7 falling sets pin16");
    wr(5'h18, 32'h0000_0001);
    idle(1);
    check("R10 pin16 pending but masked", {31'h0, irq}, 32'h0);
    rd_chk(5'h18, 32'h0001_0000, "R7 edge stays clear");

    wr(5'h0C, 32'hAAAA_AA9A);
    setpin(32'h0000_0007);
    idle(3);
    rd_chk(5'h18, 32'h0001_0004, "R6 high level sets");
    wr(5'h18, 32'h0000_0004);
    rd_chk(5'h18, 32'h0001_0004, "R6 level re-sets after clear");
    setpin(32'h0000_0003);
    idle(3);
    wr(5'h18, 32'h0000_0004);
    rd_chk(5'h18, 32'h0001_0000, "R6 level gone, clear holds");

    setpin(32'h0000_000B);
    idle(1);
    wr(5'h18, 32'h0000_0008);
    rd_chk(5'h18, 32'h0001_0008, "R9 trigger beats clear");

    wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk(5'h1C, 32'h0, "R11 unmapped reads zero");
    rd_chk(5'h14, 32'h0000_0001, "R11 write ignored");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule